// File: doc/BRIEF.md
# Banked Expansion Memory Select Decoder

This block sits on the host CPU bus of an expansion board that carries a 16 KB read-only EPROM and a 16 KB battery-backed SRAM. Software picks a bank by writing an 8-bit number to a write-only I/O port. Any I/O address whose upper byte is DFh reaches that port. The block holds the number in a bank register. It compares the register with two jumper-set bank numbers and drives the chip selects, output enable, write enable and data-bus drive enable for memory cycles in the top 16 KB of the address space.

The two memories match in different ways. The EPROM matches only on its full 8-bit bank number. The SRAM matches on the low nibble alone, so it shows up in sixteen banks. An SRAM read also needs the host's upper-ROM-enable indication. An SRAM write does not, and the block has no signal that blocks the host's internal RAM, so the host keeps its own copy of each SRAM write.

Top module: `xmb_decoder`

## Requirements
- R1: An I/O write strobe (io_req and wr both high) whose address bits 15..8 equal DFh loads data[7:0] into the bank register. Address bits 7..0 are ignored. An I/O read of that port, or an I/O write to any other upper byte, leaves the bank register unchanged.
- R2: The bank register takes the data seen in the last clock cycle of the strobe. It changes on the clock edge that first samples the strobe inactive and keeps its old value while the strobe is active.
- R3: After reset (rst_n low) the bank register holds 00h.
- R4: eprom_cs is asserted for a read only when all 8 bits of the bank register equal eprom_jmp[7:0].
- R5: The SRAM matches when bank[3:0] equals sram_jmp[3:0]. Bank bits 7..4 have no effect.
- R6: No select, output enable, write enable or drive enable is asserted unless mem_req is high and addr[15:14] equals 2'b11. mem_addr always equals addr[13:0].
- R7: A read (mem_req and rd high) asserts mem_oe and bus_drive only while rom_en is high. With rom_en low, both stay low.
- R8: An SRAM write (mem_req and wr high, SRAM match, window hit) asserts sram_cs and mem_we whatever the level of rom_en. mem_we is never asserted together with eprom_cs.
- R9: If a read matches both memories, eprom_cs is asserted and sram_cs stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 16 | Host address bus |
| data | input | 8 | Host data bus (write data) |
| io_req | input | 1 | I/O request strobe, active high |
| mem_req | input | 1 | Memory request strobe, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| rom_en | input | 1 | Host upper-ROM-enable indication, active high |
| eprom_jmp | input | 8 | Jumper bank number for the EPROM |
| sram_jmp | input | 4 | Jumper bank nibble for the SRAM |
| mem_addr | output | 14 | Memory address, A13..A0 |
| eprom_cs | output | 1 | EPROM chip select |
| sram_cs | output | 1 | SRAM chip select |
| mem_oe | output | 1 | Memory output enable |
| mem_we | output | 1 | SRAM write enable |
| bus_drive | output | 1 | Enable for the board's data-bus drivers |

## Verification
The bank number selects both memories at once, so one access can match the EPROM and the SRAM in the same cycle. The bench provokes this with bank 25h against an EPROM jumper of 25h and an SRAM nibble of 5h. It expects the EPROM alone on a read and the SRAM write enable on a write. A second overlap is a bank write still in progress while a memory access checks the old bank. The bench holds the port strobe and probes a read mid-strobe. It expects the old selects until the edge that follows the strobe's release.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
    localparam int BANK_W = 8;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [BANK_W-1:0] hold;
        logic              armed;
    } latch_state_t;

    typedef struct packed {
        logic eprom_cs;
        logic sram_cs;
        logic oe;
        logic we;
        logic drive;
    } sel_t;
endpackage

// File: rtl/xmb_bank_reg.sv
module xmb_bank_reg
    import xmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] bank
);
    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe) begin
            st_d.hold  = wdata;
            st_d.armed = 1'b1;
        end else if (st_q.armed) begin
            st_d.bank  = st_q.hold;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank = st_q.bank;
endmodule

// File: rtl/xmb_bank_cmp.sv
module xmb_bank_cmp #(
    parameter int FULL_W = 8,
    parameter int CMP_W  = 8
) (
    input  logic [FULL_W-1:0] bank,
    input  logic [CMP_W-1:0]  jmp,
    output logic              hit
);
    localparam logic [FULL_W-1:0] MASK = FULL_W'((64'd1 << CMP_W) - 64'd1);

    generate
        if (CMP_W >= FULL_W) begin : g_full
            assign hit = (bank == jmp[FULL_W-1:0]);
        end else begin : g_part
            logic [FULL_W-1:0] jmp_ext;
            assign jmp_ext = {{(FULL_W-CMP_W){1'b0}}, jmp};
            assign hit = (((bank ^ jmp_ext) & MASK) == '0);
        end
    endgenerate
endmodule

// File: rtl/xmb_sel.sv
module xmb_sel
    import xmb_pkg::*;
#(
    parameter int WIN_W = 2
) (
    input  logic             mem_req,
    input  logic             rd,
    input  logic             wr,
    input  logic             rom_en,
    input  logic [WIN_W-1:0] win_bits,
    input  logic             eprom_hit,
    input  logic             sram_hit,
    output sel_t             sel
);
    logic in_win, rd_ok, wr_ok;

    always_comb begin
        in_win = mem_req && (win_bits == {WIN_W{1'b1}});
        rd_ok  = in_win && rd && rom_en;
        wr_ok  = in_win && wr;
        sel          = '0;
        sel.eprom_cs = rd_ok && eprom_hit;
        sel.sram_cs  = (rd_ok && sram_hit && !eprom_hit) || (wr_ok && sram_hit);
        sel.we       = wr_ok && sram_hit;
        sel.oe       = rd_ok && (eprom_hit || sram_hit);
        sel.drive    = sel.oe;
    end
endmodule

// File: rtl/xmb_decoder.sv
module xmb_decoder
    import xmb_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          SRAM_W   = 4,
    parameter logic [7:0]  PORT_HI  = 8'hDF,
    localparam int         WIN_W    = ADDR_W - 14,
    localparam int         OFF_W    = ADDR_W - WIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] data,
    input  logic              io_req,
    input  logic              mem_req,
    input  logic              rd,
    input  logic              wr,
    input  logic              rom_en,
    input  logic [BANK_W-1:0] eprom_jmp,
    input  logic [SRAM_W-1:0] sram_jmp,
    output logic [OFF_W-1:0]  mem_addr,
    output logic              eprom_cs,
    output logic              sram_cs,
    output logic              mem_oe,
    output logic              mem_we,
    output logic              bus_drive
);
    logic              port_wr;
    logic [BANK_W-1:0] bank_q;
    logic              eprom_hit, sram_hit;
    sel_t              sel;

    assign port_wr = io_req && wr && (addr[ADDR_W-1 -: 8] == PORT_HI);

    xmb_bank_reg u_bank (
        .clk(clk), .rst_n(rst_n), .strobe(port_wr), .wdata(data), .bank(bank_q)
    );

    xmb_bank_cmp #(.FULL_W(BANK_W), .CMP_W(BANK_W)) u_cmp_eprom (
        .bank(bank_q), .jmp(eprom_jmp), .hit(eprom_hit)
    );

    xmb_bank_cmp #(.FULL_W(BANK_W), .CMP_W(SRAM_W)) u_cmp_sram (
        .bank(bank_q), .jmp(sram_jmp), .hit(sram_hit)
    );

    xmb_sel #(.WIN_W(WIN_W)) u_sel (
        .mem_req(mem_req), .rd(rd), .wr(wr), .rom_en(rom_en),
        .win_bits(addr[ADDR_W-1 -: WIN_W]),
        .eprom_hit(eprom_hit), .sram_hit(sram_hit), .sel(sel)
    );

    assign mem_addr  = addr[OFF_W-1:0];
    assign eprom_cs  = sel.eprom_cs;
    assign sram_cs   = sel.sram_cs;
    assign mem_oe    = sel.oe;
    assign mem_we    = sel.we;
    assign bus_drive = sel.drive;
endmodule

// File: rtl/xmb_decoder_chk.sv
module xmb_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic        io_req,
    input logic        mem_req,
    input logic        rd,
    input logic        wr,
    input logic        rom_en,
    input logic        eprom_cs,
    input logic        sram_cs,
    input logic        mem_oe,
    input logic        mem_we,
    input logic        bus_drive,
    input logic [7:0]  bank_q
);
    logic strb;
    assign strb = io_req && wr && (addr[15:8] == 8'hDF);

    // R2: bank changes only on the edge after the strobe was seen inactive
    a_r2_commit_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q != $past(bank_q)) |-> !$past(strb));

    // R6: nothing asserted outside the window
    a_r6_window_only: assert property (@(posedge clk) disable iff (!rst_n)
        (eprom_cs || sram_cs || mem_oe || mem_we || bus_drive) |-> (mem_req && addr[15:14] == 2'b11));

    // R7: drive only on enabled reads
    a_r7_drive_gated: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> (rd && rom_en && mem_oe));

    // R8: write enable goes to the SRAM alone
    a_r8_we_sram_only: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (sram_cs && !eprom_cs && wr));

    // R9: at most one chip select
    a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eprom_cs, sram_cs}));
endmodule

bind xmb_decoder xmb_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .io_req(io_req), .mem_req(mem_req),
    .rd(rd), .wr(wr), .rom_en(rom_en), .eprom_cs(eprom_cs), .sram_cs(sram_cs),
    .mem_oe(mem_oe), .mem_we(mem_we), .bus_drive(bus_drive), .bank_q(bank_q)
);

// File: tb/xmb_decoder_tb.sv
`timescale 1ns/1ps
module xmb_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  data = '0;
    logic        io_req = 0, mem_req = 0, rd = 0, wr = 0, rom_en = 0;
    logic [7:0]  eprom_jmp = 8'h25;
    logic [3:0]  sram_jmp = 4'h5;
    logic [13:0] mem_addr;
    logic        eprom_cs, sram_cs, mem_oe, mem_we, bus_drive;

    int compared = 0, mismatched = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xmb_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .data(data), .io_req(io_req),
        .mem_req(mem_req), .rd(rd), .wr(wr), .rom_en(rom_en),
        .eprom_jmp(eprom_jmp), .sram_jmp(sram_jmp), .mem_addr(mem_addr),
        .eprom_cs(eprom_cs), .sram_cs(sram_cs), .mem_oe(mem_oe),
        .mem_we(mem_we), .bus_drive(bus_drive)
    );

    // {bank, addr, rd, wr, rom_en, expected {eprom_cs,sram_cs,oe,we,drive}}
    typedef struct packed {
        logic [7:0]  bank;
        logic [15:0] a;
        logic        r, w, re;
        logic [4:0]  exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{8'h25, 16'hC000, 1'b1, 1'b0, 1'b1, 5'b10101},  // R4 R9 overlap read
        '{8'h25, 16'hFFFF, 1'b1, 1'b0, 1'b0, 5'b00000},  // R7 rom disabled
        '{8'h15, 16'hC123, 1'b1, 1'b0, 1'b1, 5'b01101},  // R5
        '{8'hF5, 16'hE000, 1'b1, 1'b0, 1'b1, 5'b01101},  // R5 upper nibble ignored
        '{8'h15, 16'h8000, 1'b1, 1'b0, 1'b1, 5'b00000},  // R6 outside window
        '{8'h15, 16'hD000, 1'b0, 1'b1, 1'b0, 5'b01010},  // R8 write, rom off
        '{8'h15, 16'hD000, 1'b0, 1'b1, 1'b1, 5'b01010},  // R8 write, rom on
        '{8'h25, 16'hC000, 1'b0, 1'b1, 1'b1, 5'b01010},  // R8 overlap write
        '{8'h24, 16'hC000, 1'b1, 1'b0, 1'b1, 5'b00000},  // R4 R5 no match
        '{8'h24, 16'hC000, 1'b0, 1'b1, 1'b0, 5'b00000},  // R8 no match write
        '{8'h35, 16'hC000, 1'b1, 1'b0, 1'b1, 5'b01101},  // R4 one bit off
        '{8'h25, 16'hBFFF, 1'b0, 1'b1, 1'b1, 5'b00000}   // R6 below window
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {eprom_cs, sram_cs, mem_oe, mem_we, bus_drive};
    endfunction

    task automatic port_write(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] v);
        @(negedge clk);
        addr = {hi, lo}; data = v; io_req = 1; wr = 1;
        @(negedge clk); @(negedge clk);
        io_req = 0; wr = 0; data = 8'h00;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic probe(input logic [15:0] a, input logic r, input logic w, input logic re);
        @(negedge clk);
        addr = a; mem_req = 1; rd = r; wr = w; rom_en = re;
        #1;
    endtask

    task automatic idle();
        mem_req = 0; rd = 0; wr = 0; rom_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R3: reset bank is 00h: EPROM jumper 00h matches
        eprom_jmp = 8'h00; sram_jmp = 4'h0;
        probe(16'hC000, 1, 0, 1);
        check("R3 reset outputs under reset", 32'(outs()), 32'b10101);
        idle();
        rst_n = 1;
        probe(16'hC000, 1, 0, 1);
        check("R3 bank 00h after reset", 32'(outs()), 32'b10101);
        idle();
        eprom_jmp = 8'h25; sram_jmp = 4'h5;

        for (int i = 0; i < NV; i++) begin
            port_write(8'hDF, 8'(i * 37), VT[i].bank);
            probe(VT[i].a, VT[i].r, VT[i].w, VT[i].re);
            check($sformatf("R4-9 vector %0d", i), 32'(outs()), 32'(VT[i].exp));
            check("R6 mem_addr", 32'(mem_addr), 32'(VT[i].a[13:0]));
            idle();
        end

        // R1: other port upper byte ignored (bank stays 25h)
        port_write(8'hDF, 8'h00, 8'h25);
        port_write(8'hDE, 8'hDF, 8'h15);
        probe(16'hC000, 1, 0, 1);
        check("R1 other port ignored", 32'(outs()), 32'b10101);
        idle();

        // R1: I/O read of the port ignored
        @(negedge clk);
        addr = 16'hDF00; data = 8'h15; io_req = 1; rd = 1;
        @(negedge clk); @(negedge clk);
        io_req = 0; rd = 0;
        probe(16'hC000, 1, 0, 1);
        check("R1 port read ignored", 32'(outs()), 32'b10101);
        idle();

        // R1: any low byte reaches the port
        port_write(8'hDF, 8'hFF, 8'h15);
        probe(16'hC000, 1, 0, 1);
        check("R1 low byte ignored", 32'(outs()), 32'b01101);
        idle();

        // R2: old bank held while strobe active, last data committed after release
        @(negedge clk);
        addr = 16'hDF00; data = 8'h24; io_req = 1; wr = 1;
        @(negedge clk);
        data = 8'h25;
        @(negedge clk);
        io_req = 0; wr = 0;
        addr = 16'hC000; mem_req = 1; rd = 1; rom_en = 1;
        #1;
        check("R2 old bank during strobe", 32'(outs()), 32'b01101);
        @(negedge clk); #1;
        check("R2 last data after release", 32'(outs()), 32'b10101);
        idle();

        // R3: reset mid-run returns bank to 00h
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        sram_jmp = 4'h0;
        probe(16'hC000, 1, 0, 1);
        check("R3 reset clears bank", 32'(outs()), 32'b01101);
        idle();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule